// File: doc/BRIEF.md
# Change-of-Flow Trace Qualifier

This block sits between the CPU's execution stage and a trace capture FIFO. Once per bus cycle it receives a code for the class of the instruction that just completed, together with its taken flag, its source (opcode) address and its destination address. From these it decides whether the instruction broke sequential flow and, if so, which of the two addresses the trace should keep. Taken conditional branches keep the source address. Indirect jumps, indirect calls, interrupt entry and the two return kinds keep the destination address. Every other class keeps nothing.

Addresses that are selected pass through a fixed two-stage register delay before reaching the FIFO push port. A trace mode input chooses how the trigger pulse gates recording. In begin-trace mode, recording opens only after the trigger. Because of the delay, flow changes in the trigger cycle and in the two cycles after it are lost. In end-trace mode, recording runs from reset and closes after the trigger cycle. A flow change in the trigger cycle is therefore the last entry pushed. A full indication from the FIFO halts recording until the next reset.

Top module: `cof_trace_qual`

## Requirements
- R1: A class code of 1 (conditional branch) with `br_taken` high yields a push of `src_addr`.
- R2: Class codes 2 (branch-always) and 3 (branch-never), 4 (direct jump) and 5 (direct call), 0 and 11 to 15 (sequential or no instruction), and code 1 with `br_taken` low never yield a push.
- R3: Class codes 6 (indirect jump) and 7 (indirect call) yield a push of `dst_addr`.
- R4: Class codes 8 (interrupt entry), 9 (return from interrupt) and 10 (return from subroutine) yield a push of `dst_addr`.
- R5: A recorded event presented in cycle t shows `push` high with its address in cycle t+2. Events in consecutive cycles come out in consecutive cycles, in the same order.
- R6: With `trace_mode_end` = 0 (begin mode), no event before the first trigger is recorded. Events in the trigger cycle and in the two cycles after it are dropped. Events from the third cycle after the trigger onward are recorded.
- R7: With `trace_mode_end` = 1 (end mode), events from reset up to and including the trigger cycle are recorded. No later event is recorded, and later triggers change nothing.
- R8: While `fifo_full` is high, `push` is low. After `fifo_full` has been high in any cycle, no push occurs until reset.
- R9: Reset (asynchronous, active low) drives `push` low and discards every event held in the delay stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_class | input | 4 | Class code of the instruction completing this cycle |
| br_taken | input | 1 | Branch condition was true (conditional branches) |
| src_addr | input | 16 | Address of the instruction's opcode |
| dst_addr | input | 16 | Address execution continues at |
| trig | input | 1 | Trigger pulse from the comparator logic |
| trace_mode_end | input | 1 | 0 = begin-trace, 1 = end-trace |
| fifo_full | input | 1 | Capture FIFO cannot accept more entries |
| push | output | 1 | FIFO write strobe |
| push_addr | output | 16 | Address written into the FIFO |

## Verification
The bench uses the default parameters: 16-bit addresses and two delay stages. With these values, the recorded-event latency is two cycles and the begin-mode blind window is three cycles. Both are short enough that each cycle at the edge of the window can be checked by hand. In begin mode, the bench places flow changes one cycle before the trigger, in the trigger cycle, in each of the two blind cycles and in the first two open cycles. In end mode, it probes the trigger-cycle entry and a repeated trigger. It also tests a one-cycle full pulse and a reset that arrives while an event is still in flight.

// File: rtl/cof_pkg.sv
package cof_pkg;

  typedef enum logic [3:0] {
    CLS_NONE    = 4'd0,
    CLS_BCOND   = 4'd1,
    CLS_BRA     = 4'd2,
    CLS_BRN     = 4'd3,
    CLS_JMP_DIR = 4'd4,
    CLS_JSR_DIR = 4'd5,
    CLS_JMP_IND = 4'd6,
    CLS_JSR_IND = 4'd7,
    CLS_IRQ     = 4'd8,
    CLS_RTI     = 4'd9,
    CLS_RTS     = 4'd10
  } cls_e;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_SRC  = 2'd1,
    PICK_DST  = 2'd2
  } pick_e;

  // Which address, if any, a completed instruction contributes to the trace.
  function automatic pick_e cof_pick(input logic [3:0] cls, input logic taken);
    pick_e p;
    case (cls)
      CLS_BCOND:                          p = taken ? PICK_SRC : PICK_NONE;
      CLS_JMP_IND, CLS_JSR_IND,
      CLS_IRQ, CLS_RTI, CLS_RTS:          p = PICK_DST;
      default:                            p = PICK_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cof_classify.sv
module cof_classify
  import cof_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [3:0]    cls,
  input  logic          taken,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  output logic          sel_vld,
  output logic [AW-1:0] sel_addr
);

  pick_e pick;

  always_comb begin
    pick     = cof_pick(cls, taken);
    sel_vld  = (pick != PICK_NONE);
    sel_addr = (pick == PICK_SRC) ? src : dst;
  end

  // R2: unconditional branch kinds never select an address
  always_comb begin
    if (cls == CLS_BRA || cls == CLS_BRN || cls == CLS_JMP_DIR || cls == CLS_JSR_DIR)
      a_r2_no_pick_uncond: assert (!sel_vld);
  end

endmodule

// File: rtl/cof_delay_pipe.sv
module cof_delay_pipe #(
  parameter int AW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  output logic          out_vld,
  output logic [AW-1:0] out_addr
);

  logic [STAGES-1:0] stg_vld;
  logic [AW-1:0]     stg_addr [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic          nxt_vld;
    logic [AW-1:0] nxt_addr;
    if (g == 0) begin : g_head
      assign nxt_vld  = in_vld;
      assign nxt_addr = in_addr;
    end else begin : g_body
      assign nxt_vld  = stg_vld[g-1];
      assign nxt_addr = stg_addr[g-1];

      // R5: each stage hands its entry on unchanged one cycle later
      a_r5_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
        stg_vld[g-1] |=> (stg_vld[g] && stg_addr[g] == $past(stg_addr[g-1])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_vld[g]  <= 1'b0;
        stg_addr[g] <= '0;
      end else begin
        stg_vld[g]  <= nxt_vld;
        stg_addr[g] <= nxt_addr;
      end
    end
  end

  assign out_vld  = stg_vld[STAGES-1];
  assign out_addr = stg_addr[STAGES-1];

endmodule

// File: rtl/cof_trace_gate.sv
module cof_trace_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic mode_end,
  input  logic fifo_full,
  output logic cap_en,
  output logic out_en
);

  localparam int CW = $clog2(STAGES + 1);
  localparam logic [CW-1:0] BLANK = CW'(STAGES);

  logic          triggered;
  logic [CW-1:0] blank_cnt;
  logic          stopped;
  logic          first_trig;

  assign first_trig = trig && !triggered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      triggered <= 1'b0;
      blank_cnt <= '0;
      stopped   <= 1'b0;
    end else begin
      if (first_trig) triggered <= 1'b1;
      if (first_trig)            blank_cnt <= BLANK;
      else if (blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;
      if (fifo_full) stopped <= 1'b1;
    end
  end

  // End mode: open until the trigger cycle inclusive.
  // Begin mode: open once the blind window after the trigger has elapsed.
  assign cap_en = mode_end ? !triggered : (triggered && blank_cnt == '0);
  assign out_en = !stopped && !fifo_full;

  // R6: the cycle right after a begin trigger is blind
  a_r6_begin_blind: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_end && first_trig) |=> !cap_en);

  // R7: after an end trigger nothing more is captured
  a_r7_end_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_end && triggered) |=> !cap_en);

  // R8: a full indication halts output for good
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !out_en);

endmodule

// File: rtl/cof_trace_qual.sv
module cof_trace_qual #(
  parameter int AW          = 16,
  parameter int PIPE_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    instr_class,
  input  logic          br_taken,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          trig,
  input  logic          trace_mode_end,
  input  logic          fifo_full,
  output logic          push,
  output logic [AW-1:0] push_addr
);

  logic          sel_vld;
  logic [AW-1:0] sel_addr;
  logic          cap_en;
  logic          out_en;
  logic          pipe_out_vld;
  logic [AW-1:0] pipe_out_addr;

  cof_classify #(.AW(AW)) u_classify (
    .cls      (instr_class),
    .taken    (br_taken),
    .src      (src_addr),
    .dst      (dst_addr),
    .sel_vld  (sel_vld),
    .sel_addr (sel_addr)
  );

  cof_trace_gate #(.STAGES(PIPE_STAGES)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .mode_end  (trace_mode_end),
    .fifo_full (fifo_full),
    .cap_en    (cap_en),
    .out_en    (out_en)
  );

  cof_delay_pipe #(.AW(AW), .STAGES(PIPE_STAGES)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (sel_vld && cap_en),
    .in_addr  (sel_addr),
    .out_vld  (pipe_out_vld),
    .out_addr (pipe_out_addr)
  );

  assign push      = pipe_out_vld && out_en;
  assign push_addr = pipe_out_addr;

  // R8: no write strobe while the FIFO reports full
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push);

  // R1: a taken conditional branch offers its source address to the pipeline
  a_r1_bcond_src: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_class == 4'd1 && br_taken) |-> (sel_vld && sel_addr == src_addr));

endmodule

// File: tb/cof_trace_qual_bench.sv
module cof_trace_qual_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  instr_class = '0;
  logic        br_taken = 1'b0;
  logic [15:0] src_addr = '0;
  logic [15:0] dst_addr = '0;
  logic        trig = 1'b0;
  logic        trace_mode_end = 1'b0;
  logic        fifo_full = 1'b0;
  logic        push;
  logic [15:0] push_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cof_trace_qual u_cof_trace_qual (
    .clk(clk), .rst_n(rst_n), .instr_class(instr_class), .br_taken(br_taken),
    .src_addr(src_addr), .dst_addr(dst_addr), .trig(trig),
    .trace_mode_end(trace_mode_end), .fifo_full(fifo_full),
    .push(push), .push_addr(push_addr)
  );

  // {class[3:0], taken, kind[1:0]} ; kind 0 none, 1 source, 2 destination
  localparam logic [6:0] VEC [16] = '{
    {4'd1,  1'b1, 2'd1}, {4'd1,  1'b0, 2'd0}, {4'd2,  1'b1, 2'd0}, {4'd3,  1'b0, 2'd0},
    {4'd4,  1'b0, 2'd0}, {4'd5,  1'b0, 2'd0}, {4'd6,  1'b0, 2'd2}, {4'd7,  1'b1, 2'd2},
    {4'd8,  1'b0, 2'd2}, {4'd9,  1'b0, 2'd2}, {4'd10, 1'b1, 2'd2}, {4'd0,  1'b1, 2'd0},
    {4'd11, 1'b0, 2'd0}, {4'd15, 1'b1, 2'd0}, {4'd2,  1'b0, 2'd0}, {4'd3,  1'b1, 2'd0}
  };

  task automatic check(input string tag, input logic ev, input logic [15:0] ea);
    n_chk++;
    if (push !== ev || (ev && push_addr !== ea)) begin
      n_fail++;
      $display("FAIL %s: push=%0b addr=%h expected push=%0b addr=%h", tag, push, push_addr, ev, ea);
    end
  endtask

  // sample at the falling edge, then drive the inputs for the next cycle
  task automatic step(input string tag, input logic ev, input logic [15:0] ea,
                      input logic [3:0] cls, input logic tk,
                      input logic [15:0] s, input logic [15:0] d, input logic tg);
    @(negedge clk);
    check(tag, ev, ea);
    instr_class = cls; br_taken = tk; src_addr = s; dst_addr = d; trig = tg;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; trace_mode_end = mode; fifo_full = 1'b0;
    instr_class = '0; br_taken = 1'b0; trig = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    do_reset(1'b1);
    #1 check("R9 reset", 1'b0, 16'h0);

    // R1 R2 R3 R4 R5: classification table in end mode with no trigger
    for (int i = 0; i < 16; i++) begin
      logic [3:0]  c  = VEC[i][6:3];
      logic        t  = VEC[i][2];
      logic [1:0]  k  = VEC[i][1:0];
      logic [15:0] s  = 16'hA000 + 16'(i);
      logic [15:0] d  = 16'hB000 + 16'(i);
      string tg = (k == 2'd1) ? "R1 source" :
                  (k == 2'd0) ? "R2 none" :
                  (c >= 4'd8) ? "R4 dest" : "R3 dest";
      step(tg, 1'b0, 16'h0, c, t, s, d, 1'b0);
      step(tg, 1'b0, 16'h0, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
      step(tg, (k != 2'd0), (k == 2'd1) ? s : d, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    end

    // R5: back-to-back events keep order and spacing
    step("R5 b2b", 1'b0, 16'h0, 4'd6, 1'b0, 16'h0, 16'hC001, 1'b0);
    step("R5 b2b", 1'b0, 16'h0, 4'd1, 1'b1, 16'hC002, 16'h0, 1'b0);
    step("R5 b2b", 1'b1, 16'hC001, 4'd9, 1'b0, 16'h0, 16'hC003, 1'b0);
    step("R5 b2b", 1'b1, 16'hC002, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R5 b2b", 1'b1, 16'hC003, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R5 b2b", 1'b0, 16'h0, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);

    // R6: begin mode, trigger at step 1, recording from step 4
    do_reset(1'b0);
    step("R6 begin", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h1000, 1'b0);
    step("R6 begin", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h1001, 1'b1);
    step("R6 begin", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h1002, 1'b0);
    step("R6 begin", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h1003, 1'b0);
    step("R6 begin", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h1004, 1'b0);
    step("R6 begin", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h1005, 1'b0);
    step("R6 begin", 1'b1, 16'h1004, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R6 begin", 1'b1, 16'h1005, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R6 begin", 1'b0, 16'h0,    4'd0, 1'b0, 16'h0, 16'h0, 1'b0);

    // R7: end mode, trigger at step 2 is last entry, later trigger ignored
    do_reset(1'b1);
    step("R7 end", 1'b0, 16'h0,    4'd8, 1'b0, 16'h0, 16'h2000, 1'b0);
    step("R7 end", 1'b0, 16'h0,    4'd10, 1'b0, 16'h0, 16'h2001, 1'b0);
    step("R7 end", 1'b1, 16'h2000, 4'd1, 1'b1, 16'h2002, 16'h0, 1'b1);
    step("R7 end", 1'b1, 16'h2001, 4'd7, 1'b0, 16'h0, 16'h2003, 1'b0);
    step("R7 end", 1'b1, 16'h2002, 4'd6, 1'b0, 16'h0, 16'h2004, 1'b0);
    step("R7 end", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h2005, 1'b1);
    step("R7 end", 1'b0, 16'h0,    4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R7 end", 1'b0, 16'h0,    4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R7 end", 1'b0, 16'h0,    4'd0, 1'b0, 16'h0, 16'h0, 1'b0);

    // R8: one-cycle full pulse stops recording for good
    do_reset(1'b1);
    step("R8 full", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h3000, 1'b0);
    step("R8 full", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h3001, 1'b0);
    step("R8 full", 1'b1, 16'h3000, 4'd6, 1'b0, 16'h0, 16'h3002, 1'b0);
    fifo_full = 1'b1;
    #1 check("R8 full now", 1'b0, 16'h0);
    step("R8 full", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h3003, 1'b0);
    fifo_full = 1'b0;
    step("R8 full", 1'b0, 16'h0,    4'd6, 1'b0, 16'h0, 16'h3004, 1'b0);
    step("R8 full", 1'b0, 16'h0,    4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    step("R8 full", 1'b0, 16'h0,    4'd0, 1'b0, 16'h0, 16'h0, 1'b0);

    // R9: reset while an event is in flight discards it
    do_reset(1'b1);
    step("R9 flush", 1'b0, 16'h0, 4'd9, 1'b0, 16'h0, 16'h4000, 1'b0);
    step("R9 flush", 1'b0, 16'h0, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);
    rst_n = 1'b0;
    #1 check("R9 flush", 1'b0, 16'h0);
    @(negedge clk);
    check("R9 flush", 1'b0, 16'h0);
    rst_n = 1'b1;
    step("R9 flush", 1'b0, 16'h0, 4'd0, 1'b0, 16'h0, 16'h0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule